// File: doc/BRIEF.md
# Fractional-Increment Precision Time Counter

This block keeps a 64-bit system time in fixed-point form. On every tick of the local oscillator it adds a programmable increment to an accumulator. Software trims the clock rate by changing the increment in very small steps, and it gets nanoseconds by shifting the accumulator right. A small register port serves three purposes: it loads the increment, it picks a link-speed profile that presets both the increment and the nanosecond shift, and it writes or clears the time. The two 32-bit time words can be read without a carry tearing the result.

A build parameter selects one of two variants. The wide variant has a 31-bit increment. The narrow variant has a 24-bit increment and an 8-bit tick-period field above it. In the narrow variant the speed presets are scaled down by 2^7 and the shift is reduced by 7, so the nanosecond value comes out the same. The period field sets how many ticks pass between additions, and its normal value is 1.

Top module: `ptc_time_counter`

## Requirements
- R1: When an addition is due, the accumulator grows by the current increment, and a carry out of the low word propagates into the high word. When no addition is due and no time write happens, the accumulator holds its value.
- R2: After reset the accumulator is zero and the speed code is 0. The increment holds the fast-link preset: 0x66666666 with shift 28 in the wide variant, or 0x00CCCCCC with period 1 and shift 21 in the narrow variant.
- R3: A write to address 1 stores the speed code from bits [1:0] and loads these presets. Code 0 or 3 (fast link or no link) gives 0x66666666 and shift 28. Code 1 gives 0x40000000 and shift 24. Code 2 gives 0x50000000 and shift 21. The accumulator is not changed.
- R4: In the narrow variant each speed preset is shifted right by 7, the shift is 7 lower, and the period field is set to 1. The increment register word is {period[7:0], increment[23:0]}.
- R5: In the narrow variant, with period P greater than 0, one addition takes place every P ticks. With P equal to 0, ticks add nothing. Any write to the increment or speed register restarts the tick count.
- R6: In the wide variant a write to address 0 keeps bits [30:0] as the increment. Bit 31 is dropped and reads back as 0.
- R7: A tick in the same cycle as an increment write uses the old increment. The new value applies from the next tick on. Writing the increment leaves the time unchanged.
- R8: A write to address 2 stages the low word. A write to address 3 loads {written word, staged low word} into the accumulator and overrides a tick in the same cycle. Writing 0 to both addresses clears the time.
- R9: A read of address 2 returns the low word and captures the high word at the same instant. A later read of address 3 returns that captured word, even if a carry has changed the high word since.
- R10: Read data and rd_valid_o appear one cycle after rd_en_i. Address 0 returns the increment word, address 1 the speed code and address 4 the shift. Other addresses read 0, and writes to them have no effect.
- R11: ns_o always equals the accumulator shifted right by shift_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oscillator tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| ns_o | output | 64 | Time in nanoseconds |
| shift_o | output | 6 | Current nanosecond shift |

## Verification
The bench reads the low word in the same cycle as a tick that carries into the high word. A design without a coherent snapshot would return a high word one too large. It also writes the increment in the same cycle as a tick, which exposes a design that applies the new value one tick early. A time load in the same cycle as a tick catches a design that lets the addition win. In the narrow variant, periods of 2 and 0 catch a period counter that is off by one tick or that ignores a zero period.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int WORD_W  = 32;
  localparam int TIME_W  = 2 * WORD_W;
  localparam int ADDR_W  = 3;
  localparam int SHIFT_W = 6;
  localparam int PER_W   = 8;
  localparam int NARROW_SHIFT = 7;

  localparam logic [ADDR_W-1:0] A_INC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SPEED = 3'd1;
  localparam logic [ADDR_W-1:0] A_TLO   = 3'd2;
  localparam logic [ADDR_W-1:0] A_THI   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SHIFT = 3'd4;

  typedef enum logic [1:0] {
    SPD_FAST  = 2'd0,
    SPD_MID   = 2'd1,
    SPD_SLOW  = 2'd2,
    SPD_NOLNK = 2'd3
  } speed_e;

  localparam logic [WORD_W-1:0] INC_FAST = 32'h6666_6666;
  localparam logic [WORD_W-1:0] INC_MID  = 32'h4000_0000;
  localparam logic [WORD_W-1:0] INC_SLOW = 32'h5000_0000;

  function automatic logic [WORD_W-1:0] preset_inc(input logic [1:0] spd, input bit narrow);
    logic [WORD_W-1:0] v;
    case (spd)
      SPD_MID:  v = INC_MID;
      SPD_SLOW: v = INC_SLOW;
      default:  v = INC_FAST;
    endcase
    return narrow ? (v >> NARROW_SHIFT) : v;
  endfunction

  function automatic logic [SHIFT_W-1:0] preset_shift(input logic [1:0] spd, input bit narrow);
    logic [SHIFT_W-1:0] s;
    case (spd)
      SPD_MID:  s = 6'd24;
      SPD_SLOW: s = 6'd21;
      default:  s = 6'd28;
    endcase
    return narrow ? s - SHIFT_W'(NARROW_SHIFT) : s;
  endfunction
endpackage

// File: rtl/ptc_inc_ctrl.sv
module ptc_inc_ctrl
  import ptc_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int INC_W  = 31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                inc_we_i,
  input  logic                spd_we_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  output logic                add_en_o,
  output logic [INC_W-1:0]    inc_o,
  output logic [PER_W-1:0]    period_o,
  output logic [WORD_W-1:0]   inc_word_o,
  output logic [1:0]          speed_o,
  output logic [SHIFT_W-1:0]  shift_o
);
  logic [INC_W-1:0]   inc_q;
  logic [1:0]         speed_q;
  logic [SHIFT_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q   <= INC_W'(preset_inc(SPD_FAST, NARROW));
      speed_q <= SPD_FAST;
      shift_q <= preset_shift(SPD_FAST, NARROW);
    end else if (spd_we_i) begin
      inc_q   <= INC_W'(preset_inc(wr_data_i[1:0], NARROW));
      speed_q <= wr_data_i[1:0];
      shift_q <= preset_shift(wr_data_i[1:0], NARROW);
    end else if (inc_we_i) begin
      inc_q   <= wr_data_i[INC_W-1:0];
    end
  end

  generate
    if (NARROW) begin : g_narrow
      logic [PER_W-1:0] per_q;
      logic [PER_W-1:0] cnt_q;
      logic             due;

      assign due = (per_q != '0) && (cnt_q == per_q - PER_W'(1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          per_q <= PER_W'(1);
          cnt_q <= '0;
        end else begin
          if (spd_we_i) begin
            per_q <= PER_W'(1);
            cnt_q <= '0;
          end else if (inc_we_i) begin
            per_q <= wr_data_i[INC_W +: PER_W];
            cnt_q <= '0;
          end else if (tick_i && per_q != '0) begin
            cnt_q <= due ? '0 : cnt_q + PER_W'(1);
          end
        end
      end

      assign add_en_o   = tick_i && due;
      assign period_o   = per_q;
      assign inc_word_o = {per_q, inc_q};
    end else begin : g_wide
      assign add_en_o   = tick_i;
      assign period_o   = PER_W'(1);
      assign inc_word_o = {{(WORD_W-INC_W){1'b0}}, inc_q};
    end
  endgenerate

  assign inc_o   = inc_q;
  assign speed_o = speed_q;
  assign shift_o = shift_q;
endmodule

// File: rtl/ptc_accum.sv
module ptc_accum
  import ptc_pkg::*;
#(
  parameter int INC_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_en_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [TIME_W-1:0] acc_o
);
  logic [TIME_W-1:0] acc_q;
  logic [WORD_W-1:0] lo_stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_stage_q <= '0;
    end else if (lo_we_i) begin
      lo_stage_q <= wr_data_i;
    end
  end

  // time load wins over a tick in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (hi_we_i) begin
      acc_q <= {wr_data_i, lo_stage_q};
    end else if (add_en_i) begin
      acc_q <= acc_q + {{(TIME_W-INC_W){1'b0}}, inc_i};
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/ptc_read_port.sv
module ptc_read_port
  import ptc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [TIME_W-1:0]  acc_i,
  input  logic [WORD_W-1:0]  inc_word_i,
  input  logic [1:0]         speed_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               rd_valid_o
);
  logic [WORD_W-1:0] snap_q;
  logic [WORD_W-1:0] rd_data_q;
  logic              rd_valid_q;
  logic [WORD_W-1:0] mux;

  always_comb begin
    case (rd_addr_i)
      A_INC:   mux = inc_word_i;
      A_SPEED: mux = {{(WORD_W-2){1'b0}}, speed_i};
      A_TLO:   mux = acc_i[WORD_W-1:0];
      A_THI:   mux = snap_q;
      A_SHIFT: mux = {{(WORD_W-SHIFT_W){1'b0}}, shift_i};
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q     <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) begin
        rd_data_q <= mux;
        if (rd_addr_i == A_TLO) snap_q <= acc_i[TIME_W-1:WORD_W];
      end
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/ptc_time_counter.sv
module ptc_time_counter
  import ptc_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               rd_valid_o,
  output logic [TIME_W-1:0]  ns_o,
  output logic [SHIFT_W-1:0] shift_o
);
  localparam int INC_W = NARROW ? 24 : 31;

  logic               inc_we, spd_we, lo_we, hi_we;
  logic               add_en;
  logic [INC_W-1:0]   inc;
  logic [PER_W-1:0]   period;
  logic [WORD_W-1:0]  inc_word;
  logic [1:0]         speed;
  logic [SHIFT_W-1:0] shift;
  logic [TIME_W-1:0]  acc;

  assign inc_we = wr_en_i && (wr_addr_i == A_INC);
  assign spd_we = wr_en_i && (wr_addr_i == A_SPEED);
  assign lo_we  = wr_en_i && (wr_addr_i == A_TLO);
  assign hi_we  = wr_en_i && (wr_addr_i == A_THI);

  ptc_inc_ctrl #(.NARROW(NARROW), .INC_W(INC_W)) u_inc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .inc_we_i   (inc_we),
    .spd_we_i   (spd_we),
    .wr_data_i  (wr_data_i),
    .add_en_o   (add_en),
    .inc_o      (inc),
    .period_o   (period),
    .inc_word_o (inc_word),
    .speed_o    (speed),
    .shift_o    (shift)
  );

  ptc_accum #(.INC_W(INC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .add_en_i  (add_en),
    .inc_i     (inc),
    .lo_we_i   (lo_we),
    .hi_we_i   (hi_we),
    .wr_data_i (wr_data_i),
    .acc_o     (acc)
  );

  ptc_read_port u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .acc_i      (acc),
    .inc_word_i (inc_word),
    .speed_i    (speed),
    .shift_i    (shift),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign ns_o    = acc >> shift;
  assign shift_o = shift;
endmodule

// File: rtl/ptc_time_counter_chk.sv
module ptc_time_counter_chk
  import ptc_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int INC_W  = 31
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [WORD_W-1:0]  wr_data_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic [WORD_W-1:0]  rd_data_o,
  input logic               rd_valid_o,
  input logic [SHIFT_W-1:0] shift_o,
  input logic               add_en,
  input logic [INC_W-1:0]   inc,
  input logic [PER_W-1:0]   period,
  input logic [TIME_W-1:0]  acc
);
  logic hi_we;
  assign hi_we = wr_en_i && (wr_addr_i == A_THI);

  // R1
  add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_en && !hi_we) |=> acc == $past(acc) + TIME_W'($past(inc)));

  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_en && !hi_we) |=> $stable(acc));

  // R5
  zero_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period == '0) |-> !add_en);

  // R8
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we |=> acc[TIME_W-1:WORD_W] == $past(wr_data_i));

  // R9
  lo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_TLO) |=> rd_data_o == $past(acc[WORD_W-1:0]));

  // R10
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  // R10
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  // R3
  speed_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SPEED) |=> shift_o == preset_shift($past(wr_data_i[1:0]), NARROW));

  // R1
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !add_en);
endmodule

bind ptc_time_counter ptc_time_counter_chk #(.NARROW(NARROW), .INC_W(INC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .shift_o    (shift_o),
  .add_en     (add_en),
  .inc        (inc),
  .period     (period),
  .acc        (acc)
);

// File: tb/ptc_time_counter_bench.sv
module ptc_time_counter_bench;
  import ptc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              sel = 1'b0;
  logic              tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;

  logic [WORD_W-1:0]  rdw, rdn;
  logic               rvw, rvn;
  logic [TIME_W-1:0]  nsw, nsn;
  logic [SHIFT_W-1:0] shw, shn;

  ptc_time_counter #(.NARROW(1'b0)) u_ptc_time_counter (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick && !sel),
    .wr_en_i(wr_en && !sel), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en && !sel), .rd_addr_i(rd_addr),
    .rd_data_o(rdw), .rd_valid_o(rvw), .ns_o(nsw), .shift_o(shw)
  );

  ptc_time_counter #(.NARROW(1'b1)) u_ptc_time_counter_narrow (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick && sel),
    .wr_en_i(wr_en && sel), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en && sel), .rd_addr_i(rd_addr),
    .rd_data_o(rdn), .rd_valid_o(rvn), .ns_o(nsn), .shift_o(shn)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [WORD_W-1:0] exp_q[$];
  string             tag_q[$];

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d, input bit tk = 1'b0);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
    cyc();
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] e, input string t,
                    input bit tk = 1'b0);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; rd_addr = a; tick = tk;
    cyc();
    rd_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
  endtask

  task automatic zero_time();
    wr(A_TLO, 32'h0);
    wr(A_THI, 32'h0);
  endtask

  task automatic chk(input string t, input logic [TIME_W-1:0] act, input logic [TIME_W-1:0] e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rvw || rvn) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 actual=unexpected read expected=none");
      end else begin
        chk(tag_q.pop_front(), TIME_W'(rvn ? rdn : rdw), TIME_W'(exp_q.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // ---- wide variant ----
    sel = 1'b0;
    chk("R2 ns", nsw, 64'h0);
    rd(A_INC,   32'h6666_6666, "R2 inc");
    rd(A_SHIFT, 32'd28,        "R2 shift");
    rd(A_TLO,   32'h0,         "R2 lo");
    rd(A_THI,   32'h0,         "R2 hi");

    ticks(10);  // 10 * 0x66666666 = 0x3_FFFFFFFC
    chk("R11 ns fast", nsw, 64'd63);
    rd(A_TLO, 32'hFFFF_FFFC, "R1 lo");
    rd(A_THI, 32'h3,         "R1 hi");

    // coherent read across a carry
    wr(A_INC, 32'h20);
    wr(A_TLO, 32'hFFFF_FFF0);
    wr(A_THI, 32'h0);
    rd(A_TLO, 32'hFFFF_FFF0, "R9 lo at carry", 1'b1);
    rd(A_THI, 32'h0,         "R9 snap hi");
    rd(A_TLO, 32'h10,        "R9 lo after");
    rd(A_THI, 32'h1,         "R9 hi after");

    // new increment applies from the next tick
    zero_time();
    wr(A_INC, 32'h5, 1'b1);
    ticks(1);
    rd(A_TLO, 32'h25, "R7 inc timing");
    rd(A_INC, 32'h5,  "R7 inc read");
    rd(A_TLO, 32'h25, "R7 time kept");

    // load beats tick
    wr(A_TLO, 32'h100);
    wr(A_THI, 32'h7, 1'b1);
    rd(A_TLO, 32'h100, "R8 load lo");
    rd(A_THI, 32'h7,   "R8 load hi");
    zero_time();
    rd(A_TLO, 32'h0, "R8 zero lo");
    rd(A_THI, 32'h0, "R8 zero hi");

    // bit 31 of increment dropped
    wr(A_INC, 32'hFFFF_FFFF);
    rd(A_INC, 32'h7FFF_FFFF, "R6 inc mask");
    ticks(1);
    rd(A_TLO, 32'h7FFF_FFFF, "R6 add");

    // speed presets
    wr(A_SPEED, 32'h1);
    rd(A_INC,   32'h4000_0000, "R3 mid inc");
    rd(A_SHIFT, 32'd24,        "R3 mid shift");
    rd(A_SPEED, 32'h1,         "R3 mid code");
    rd(A_TLO,   32'h7FFF_FFFF, "R3 time kept");
    zero_time();
    ticks(4);
    chk("R11 ns mid", nsw, 64'd256);
    wr(A_SPEED, 32'h2);
    zero_time();
    ticks(1);
    chk("R11 ns slow", nsw, 64'd640);
    chk("R3 slow shift", TIME_W'(shw), 64'd21);
    rd(A_TLO, 32'h5000_0000, "R3 slow lo");
    wr(A_SPEED, 32'h3);
    rd(A_INC,   32'h6666_6666, "R3 nolink inc");
    rd(A_SHIFT, 32'd28,        "R3 nolink shift");

    // unmapped addresses
    wr(3'd5, 32'hDEAD_BEEF);
    wr(3'd7, 32'h1234_5678);
    rd(A_INC, 32'h6666_6666, "R10 unmapped write inc");
    rd(A_TLO, 32'h5000_0000, "R10 unmapped write time");
    rd(3'd6,  32'h0,         "R10 unmapped read");

    // ---- narrow variant ----
    sel = 1'b1;
    rd(A_INC,   32'h01CC_CCCC, "R4 reset inc");
    rd(A_SHIFT, 32'd21,        "R4 reset shift");
    ticks(10);  // 10 * 0xCCCCCC = 0x7FFFFF8
    chk("R4 ns", nsn, 64'd63);
    wr(A_SPEED, 32'h1);
    rd(A_INC,   32'h0180_0000, "R4 mid inc");
    rd(A_SHIFT, 32'd17,        "R4 mid shift");

    wr(A_INC, 32'h0200_0010);  // period 2, increment 0x10
    zero_time();
    ticks(4);
    rd(A_TLO, 32'h20, "R5 period two");
    ticks(3);
    rd(A_TLO, 32'h30, "R5 period phase");
    wr(A_INC, 32'h0000_0010);  // period 0
    ticks(5);
    rd(A_TLO, 32'h30, "R5 period zero");
    wr(A_SPEED, 32'h0);
    rd(A_INC, 32'h01CC_CCCC, "R4 speed restores period");

    repeat (3) cyc();
    chk("R10 drained", TIME_W'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule